// File: doc/BRIEF.md
# Serial Controller Host Register Front End

This block is the byte-wide host port of a two-channel serial controller. The host reaches each channel through two ports: a control port and a data port. Control traffic is indirect. A write made while a channel's pointer is zero loads a register number and may carry a command. The next control access then reaches that register, and the pointer falls back to zero after it. A "point high" command reaches the upper eight registers. A write to the master register (register 9) can reset either channel or both.

The block holds sixteen write registers and sixteen read registers per channel. It exposes every write register on a flat bus for the shift engines and rate logic. It also emits single-cycle strobes for the neighbouring blocks: a transmit byte, a receive-read notice, clear-transmit-interrupt, clear-in-service and channel reset. Read data is registered and is valid in the cycle after the read strobe. All other strobes are also registered and appear in the cycle after the access.

Top module: `sccHostPort`

## Requirements
- R1: Address bit ADDR_SHIFT selects the port (0 = control, 1 = data). Address bit ADDR_SHIFT+1 selects the channel (0 = channel B, 1 = channel A). Each channel keeps its own pointer, and data-port traffic never moves a pointer.
- R2: A control write made while the channel pointer is 0 loads data bits 2:0 into pointer bits 2:0. The next control write then stores its byte into that write register, visible on `wrRegs` at bits [(ch*16+reg)*8 +: 8].
- R3: When data bits 5:3 of a pointer-loading write equal 1, pointer bit 3 is set, so registers 8 to 15 become reachable.
- R4: The pointer returns to 0 after any control read and after any control write to a nonzero register other than register 9.
- R5: A control read returns, on `rdData` in the cycle after the strobe, the read register selected by the pointer. Read register 0 resets to 0x44 and read register 1 resets to 0x07. Every other read register resets to 0x00.
- R6: A write to register 12 or register 13 is also copied into read register 12 or 13 of the same channel.
- R7: A write to register 9 is never stored. Data bits 7:6 act as follows: 01 resets channel B, 10 resets channel A, 11 resets both, and 00 does nothing and returns the pointer to 0. With a nonzero code, the writing channel's pointer stays at 9 unless that channel is itself reset.
- R8: A channel reset, or `rstN` low, sets that channel's write registers 4=0x04, 9=0xC0, 11=0x08, 14=0x30 and 15=0xF8, with all others 0x00. It also sets the channel's read registers to their reset values and its pointer to 0.
- R9: Command code 5 in bits 5:3 of a pointer-loading write pulses `txIntClr` for that channel. Command code 7 pulses `iusClr` for that channel. Each pulse lasts one cycle, in the cycle after the write.
- R10: A data-port write pulses `txStrobe` for its channel and presents the byte on `txByte`, in the cycle after the write.
- R11: A data-port read pulses `rxReadStrobe` for its channel and returns that channel's `rxHold` byte on `rdData`, in the cycle after the read.
- R12: `chanRstOut` pulses for one cycle, in the cycle after a register-9 write, with bit 0 for channel B and bit 1 for channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_SHIFT+2 | Byte address; port bit and channel bit |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| wrData | input | 8 | Write byte |
| rxHold | input | 16 | Received byte per channel (B in 7:0, A in 15:8) |
| rdData | output | 8 | Registered read data |
| wrRegs | output | 256 | All write registers, channel-major |
| txStrobe | output | 2 | Transmit byte strobe per channel |
| txByte | output | 8 | Byte written to the data port |
| rxReadStrobe | output | 2 | Data-port read notice per channel |
| txIntClr | output | 2 | Clear-transmit-interrupt strobe per channel |
| iusClr | output | 2 | Clear-in-service strobe per channel |
| chanRstOut | output | 2 | Channel reset strobe per channel |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high in the same cycle. They also assume that each strobe lasts exactly one clock, so that every pointer step corresponds to a single access. The bench drives every access as a one-cycle pulse from a task that raises one enable only and drops it at the next falling edge. It then samples the registered outputs in that same low phase. The sequences cover the order-dependent cases: pointer loads followed by reads, a master reset issued from the other channel, and a second master write that proves the pointer stayed at 9.

// File: rtl/sccHostPkg.sv
package sccHostPkg;
  localparam int NCH    = 2;
  localparam int NREG   = 16;
  localparam int DW     = 8;
  localparam int PTR_W  = $clog2(NREG);
  localparam int CMD_W  = 3;

  localparam logic [CMD_W-1:0] CMD_POINT_HIGH = 3'd1;
  localparam logic [CMD_W-1:0] CMD_TX_CLR     = 3'd5;
  localparam logic [CMD_W-1:0] CMD_IUS_CLR    = 3'd7;

  localparam logic [PTR_W-1:0] MASTER_REG = 4'd9;
  localparam logic [PTR_W-1:0] DIV_LO_REG = 4'd12;
  localparam logic [PTR_W-1:0] DIV_HI_REG = 4'd13;

  typedef struct packed {
    logic [NCH-1:0]   chanRst;
    logic             regWr;
    logic             rdCtrl;
    logic             rdRx;
    logic             chSel;
    logic [PTR_W-1:0] regIdx;
    logic [DW-1:0]    data;
  } hostStrobeT;

  function automatic logic [DW-1:0] wrRstVal(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] rdRstVal(input int idx);
    case (idx)
      0:       return 8'h44;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sccHostCtrl.sv
module sccHostCtrl
  import sccHostPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            portSel,
  input  logic            chanSel,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [DW-1:0]   wrData,
  output hostStrobeT      strb,
  output logic [NCH-1:0]  txStrobe,
  output logic [DW-1:0]   txByte,
  output logic [NCH-1:0]  rxReadStrobe,
  output logic [NCH-1:0]  txIntClr,
  output logic [NCH-1:0]  iusClr,
  output logic [NCH-1:0]  chanRstOut
);
  logic [NCH-1:0][PTR_W-1:0] ptrQ, ptrD;
  logic [PTR_W-1:0] curPtr;
  logic [CMD_W-1:0] cmdCode;
  logic ctrlWr, ctrlRd, dataWr, dataRd;
  logic [NCH-1:0] txClrD, iusClrD;

  always_comb begin
    curPtr  = ptrQ[chanSel];
    cmdCode = wrData[5:3];
    ctrlWr  = wrEn & ~portSel;
    dataWr  = wrEn &  portSel;
    ctrlRd  = rdEn & ~wrEn & ~portSel;
    dataRd  = rdEn & ~wrEn &  portSel;

    ptrD    = ptrQ;
    txClrD  = '0;
    iusClrD = '0;
    strb         = '0;
    strb.chSel   = chanSel;
    strb.regIdx  = curPtr;
    strb.data    = wrData;

    if (ctrlWr) begin
      if (curPtr == '0) begin
        ptrD[chanSel] = {cmdCode == CMD_POINT_HIGH, wrData[PTR_W-2:0]};
        if (cmdCode == CMD_TX_CLR)  txClrD[chanSel]  = 1'b1;
        if (cmdCode == CMD_IUS_CLR) iusClrD[chanSel] = 1'b1;
      end else if (curPtr == MASTER_REG) begin
        strb.chanRst = {wrData[7], wrData[6]};
        if (wrData[7:6] == 2'b00) ptrD[chanSel] = '0;
        for (int c = 0; c < NCH; c++)
          if (strb.chanRst[c]) ptrD[c] = '0;
      end else begin
        strb.regWr    = 1'b1;
        ptrD[chanSel] = '0;
      end
    end
    if (ctrlRd) begin
      strb.rdCtrl   = 1'b1;
      ptrD[chanSel] = '0;
    end
    if (dataRd) strb.rdRx = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ         <= '0;
      txStrobe     <= '0;
      txByte       <= '0;
      rxReadStrobe <= '0;
      txIntClr     <= '0;
      iusClr       <= '0;
      chanRstOut   <= '0;
    end else begin
      ptrQ       <= ptrD;
      txIntClr   <= txClrD;
      iusClr     <= iusClrD;
      chanRstOut <= strb.chanRst;
      for (int c = 0; c < NCH; c++) begin
        txStrobe[c]     <= dataWr && (chanSel == 1'(c));
        rxReadStrobe[c] <= dataRd && (chanSel == 1'(c));
      end
      if (dataWr) txByte <= wrData;
    end
  end

  // R1
  access_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));

  // R4
  ptr_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !portSel) |=> (ptrQ[$past(chanSel)] == '0));

  // R7
  mstr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !portSel && curPtr == MASTER_REG && wrData[7:6] == 2'b00)
      |=> (ptrQ[$past(chanSel)] == '0 && chanRstOut == '0));

  // R10
  tx_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txStrobe != '0) |-> (txByte == $past(wrData) && $onehot0(txStrobe)));

  generate
    for (genvar c = 0; c < NCH; c++) begin : gChk
      // R12
      rst_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
        chanRstOut[c] |-> (ptrQ[c] == '0));
    end
  endgenerate
endmodule

// File: rtl/sccHostRegs.sv
module sccHostRegs
  import sccHostPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  hostStrobeT              strb,
  input  logic [NCH*DW-1:0]       rxHold,
  output logic [DW-1:0]           rdData,
  output logic [NCH*NREG*DW-1:0]  wrRegs
);
  logic [NCH-1:0][NREG-1:0][DW-1:0] rdAll;

  generate
    for (genvar c = 0; c < NCH; c++) begin : gChan
      logic [NREG-1:0][DW-1:0] wregL;
      logic [NREG-1:0][DW-1:0] rregL;
      logic selMe;

      assign selMe = strb.regWr && (strb.chSel == 1'(c));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int r = 0; r < NREG; r++) begin
            wregL[r] <= wrRstVal(r);
            rregL[r] <= rdRstVal(r);
          end
        end else if (strb.chanRst[c]) begin
          for (int r = 0; r < NREG; r++) begin
            wregL[r] <= wrRstVal(r);
            rregL[r] <= rdRstVal(r);
          end
        end else if (selMe) begin
          wregL[strb.regIdx] <= strb.data;
          if (strb.regIdx == DIV_LO_REG || strb.regIdx == DIV_HI_REG)
            rregL[strb.regIdx] <= strb.data;
        end
      end

      assign wrRegs[c*NREG*DW +: NREG*DW] = wregL;
      assign rdAll[c] = rregL;

      // R8
      rst_values_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(strb.chanRst[c]) |-> (wregL[MASTER_REG] == 8'hC0 &&
          wregL[4] == 8'h04 && rregL[0] == 8'h44 && rregL[1] == 8'h07));

      // R6
      div_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(selMe && !strb.chanRst[c] && strb.regIdx == DIV_LO_REG)
          |-> (rregL[DIV_LO_REG] == $past(strb.data)));

      // R7
      mstr_nostore_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(strb.chanRst == '0) |-> (wregL[MASTER_REG] == $past(wregL[MASTER_REG])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.rdCtrl)
      rdData <= rdAll[strb.chSel][strb.regIdx];
    else if (strb.rdRx)
      rdData <= rxHold[strb.chSel*DW +: DW];
  end
endmodule

// File: rtl/sccHostPort.sv
module sccHostPort
  import sccHostPkg::*;
#(
  parameter int ADDR_SHIFT = 0,
  localparam int ADDR_W    = ADDR_SHIFT + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [7:0]                  wrData,
  input  logic [15:0]                 rxHold,
  output logic [7:0]                  rdData,
  output logic [255:0]                wrRegs,
  output logic [1:0]                  txStrobe,
  output logic [7:0]                  txByte,
  output logic [1:0]                  rxReadStrobe,
  output logic [1:0]                  txIntClr,
  output logic [1:0]                  iusClr,
  output logic [1:0]                  chanRstOut
);
  hostStrobeT strb;

  sccHostCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .portSel      (addr[ADDR_SHIFT]),
    .chanSel      (addr[ADDR_SHIFT+1]),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .wrData       (wrData),
    .strb         (strb),
    .txStrobe     (txStrobe),
    .txByte       (txByte),
    .rxReadStrobe (rxReadStrobe),
    .txIntClr     (txIntClr),
    .iusClr       (iusClr),
    .chanRstOut   (chanRstOut)
  );

  sccHostRegs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rxHold (rxHold),
    .rdData (rdData),
    .wrRegs (wrRegs)
  );
endmodule

// File: tb/sccHostPort_tb.sv
module sccHostPort_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] CB = 2'b00, DB = 2'b01, CA = 2'b10, DA = 2'b11;
  localparam int NVEC = 18;
  // {isRead, addr, data, expected read}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, CA, 8'h0C, 8'h00}, {1'b0, CA, 8'h34, 8'h00},
    {1'b0, CA, 8'h0C, 8'h00}, {1'b1, CA, 8'h00, 8'h34},
    {1'b1, CA, 8'h00, 8'h44}, {1'b0, CA, 8'h0D, 8'h00},
    {1'b0, CA, 8'h56, 8'h00}, {1'b0, CA, 8'h0D, 8'h00},
    {1'b1, CA, 8'h00, 8'h56}, {1'b0, CB, 8'h01, 8'h00},
    {1'b1, CB, 8'h00, 8'h07}, {1'b0, CB, 8'h0C, 8'h00},
    {1'b1, CB, 8'h00, 8'h00}, {1'b0, CB, 8'h03, 8'h00},
    {1'b0, CB, 8'hA5, 8'h00}, {1'b1, CB, 8'h00, 8'h44},
    {1'b0, CA, 8'h02, 8'h00}, {1'b1, CA, 8'h00, 8'h00}
  };

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [15:0] rxHold = '0;
  logic [7:0] rdData, txByte;
  logic [255:0] wrRegs;
  logic [1:0] txStrobe, rxReadStrobe, txIntClr, iusClr, chanRstOut;
  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sccHostPort u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rxHold(rxHold), .rdData(rdData), .wrRegs(wrRegs),
    .txStrobe(txStrobe), .txByte(txByte), .rxReadStrobe(rxReadStrobe),
    .txIntClr(txIntClr), .iusClr(iusClr), .chanRstOut(chanRstOut)
  );

  function automatic logic [7:0] wv(input int ch, input int r);
    return wrRegs[(ch*16+r)*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit isRd, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = !isRd; rdEn = isRd;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 R5 reset state
    chk("R5 reset rdData", rdData, 8'h00);
    chk("R12 reset chanRstOut", chanRstOut, 2'b00);
    chk("R8 A reg15", wv(1,15), 8'hF8);
    chk("R8 B reg11", wv(0,11), 8'h08);
    chk("R8 A reg14", wv(1,14), 8'h30);
    chk("R8 B reg4", wv(0,4), 8'h04);

    // Vector walk: R2 R3 R4 R5 R6 R1
    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
      if (VEC[i][18]) chk("R5 R3 R4 vector read", rdData, VEC[i][7:0]);
    end
    chk("R2 B reg3 stored", wv(0,3), 8'hA5);
    chk("R6 A reg12 stored", wv(1,12), 8'h34);
    chk("R3 A reg13 stored", wv(1,13), 8'h56);

    // R7 reset B from channel A; pointer of A stays at 9
    acc(0, CA, 8'h09);
    acc(0, CA, 8'h40);
    chk("R12 reset B strobe", chanRstOut, 2'b01);
    chk("R8 B reg3 cleared", wv(0,3), 8'h00);
    chk("R7 A untouched", wv(1,12), 8'h34);
    chk("R7 A reg9 not stored", wv(1,9), 8'hC0);
    acc(0, CA, 8'h80);
    chk("R7 pointer held, A reset", chanRstOut, 2'b10);
    chk("R8 A reg12 cleared", wv(1,12), 8'h00);
    // R7 code 00
    acc(0, CA, 8'h09);
    acc(0, CA, 8'h00);
    chk("R7 code 00 no reset", chanRstOut, 2'b00);
    chk("R7 code 00 not stored", wv(1,9), 8'hC0);
    acc(1, CA, 8'h00);
    chk("R7 code 00 pointer home", rdData, 8'h44);

    // R7 reset both
    acc(0, CB, 8'h04);
    acc(0, CB, 8'h01);
    chk("R2 B reg4 written", wv(0,4), 8'h01);
    acc(0, CA, 8'h0C);
    acc(0, CA, 8'h77);
    acc(0, CB, 8'h09);
    acc(0, CB, 8'hC0);
    chk("R12 reset both strobe", chanRstOut, 2'b11);
    chk("R8 B reg4 restored", wv(0,4), 8'h04);
    chk("R8 A reg12 restored", wv(1,12), 8'h00);
    acc(0, CA, 8'h0C);
    acc(1, CA, 8'h00);
    chk("R8 A read reg12 restored", rdData, 8'h00);

    // R9 commands
    acc(0, CB, 8'h28);
    chk("R9 tx clear B", txIntClr, 2'b01);
    chk("R9 no ius on code 5", iusClr, 2'b00);
    acc(0, CA, 8'h38);
    chk("R9 ius clear A", iusClr, 2'b10);
    chk("R9 no tx clear on code 7", txIntClr, 2'b00);
    @(negedge clk);
    chk("R9 strobe one cycle", iusClr, 2'b00);

    // R10 data writes, R1 pointer untouched by data traffic
    acc(0, CB, 8'h01);
    acc(0, DA, 8'h5A);
    chk("R10 tx strobe A", txStrobe, 2'b10);
    chk("R10 tx byte A", txByte, 8'h5A);
    acc(0, DB, 8'hA5);
    chk("R10 tx strobe B", txStrobe, 2'b01);
    chk("R10 tx byte B", txByte, 8'hA5);
    chk("R1 data write not in regs", wv(0,1), 8'h00);
    acc(1, CB, 8'h00);
    chk("R1 pointer kept over data", rdData, 8'h07);

    // R11 data reads
    rxHold = {8'hC3, 8'h3C};
    acc(1, DB, 8'h00);
    chk("R11 rx data B", rdData, 8'h3C);
    chk("R11 rx strobe B", rxReadStrobe, 2'b01);
    acc(1, DA, 8'h00);
    chk("R11 rx data A", rdData, 8'hC3);
    chk("R11 rx strobe A", rxReadStrobe, 2'b10);
    @(negedge clk);
    chk("R11 strobe one cycle", rxReadStrobe, 2'b00);

    report();
  end
endmodule